// File: doc/BRIEF.md
# DMA Event and Interrupt Router

This block sits beside the thread sequencers of a multi-thread DMA engine and decides what happens when any thread (up to eight channel threads plus one manager thread) executes a send-event for an event number N. A per-event routing mask decides the outcome. With the mask bit clear, the event is posted internally so that threads waiting on N can continue. With the mask bit set, the matching level-sensitive interrupt line toward the CPU is raised. That line stays high until software acknowledges it.

Software reaches the block through a small register port with four selectable words: the routing mask, a write-1-to-acknowledge word for the interrupt lines, a raw status word that reflects the interrupt levels, and a fault word. A fault reported by the engine sets a sticky fault flag that drives a dedicated fault interrupt until software acknowledges it. The thread-release outputs are driven combinationally from the internally posted events and the waiting threads' requests. The thread sequencers use them to resume execution.

Top module: `dma_evt_router`

## Requirements
- R1: While `rst` is high at a clock edge, the routing mask, all interrupt lines, all posted internal events and the fault flag are cleared. After reset, `irq_o`, `fault_irq_o` and `release_o` are all zero and every register read returns 0.
- R2: A send-event for N while mask bit N is 0 leaves every bit of `irq_o` unchanged and posts internal event N from the next cycle on.
- R3: A send-event for N while mask bit N is 1 makes `irq_o[N]` high from the cycle after the request.
- R4: An interrupt line that is high stays high in every following cycle until it is acknowledged.
- R5: Writing select 1 (acknowledge word) with bit N = 1 makes `irq_o[N]` low from the next cycle. Bits written as 0 leave their lines unchanged, and select 1 reads back as 0.
- R6: When a routed send-event for N and an acknowledge of bit N fall in the same cycle, `irq_o[N]` is high in the next cycle.
- R7: A high `fault_i` sets the fault flag from the next cycle. `fault_irq_o` and bit 0 of select 3 show the flag. Writing select 3 with bit 0 = 1 clears it, writing bit 0 = 0 does not, and a new fault in the same cycle as the clear wins.
- R8: In any cycle in which internal event N is posted, every thread k with `wait_valid_i[k]` high and wait index N sees `release_o[k]` high in that same cycle. A thread that is not waiting is never released.
- R9: A posted internal event stays posted across cycles in which no thread waits on it. It is withdrawn at the end of the first cycle in which at least one thread is released on it, unless a new send-event for it arrives in that cycle.
- R10: Register writes take effect at the next clock edge. A send-event issued in the same cycle as a mask write is routed by the old mask, and select 0 reads back the mask.
- R11: Reading select 2 returns the current level of every interrupt line, with bit N equal to `irq_o[N]`.
- R12: Any of the nine threads may issue a send-event. Requests from several threads in one cycle all take effect, including requests for different event numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sev_valid_i | input | 9 | Per-thread send-event request |
| sev_idx_i | input | 45 | Per-thread event number, 5 bits per thread, thread k at bits 5k+4:5k |
| wait_valid_i | input | 9 | Per-thread wait-for-event request |
| wait_idx_i | input | 45 | Per-thread awaited event number, same packing as `sev_idx_i` |
| fault_i | input | 1 | Engine fault indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 mask, 1 acknowledge, 2 status (no effect), 3 fault |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as `wr_sel_i` |
| rd_data_o | output | 32 | Read data for `rd_sel_i`, combinational |
| irq_o | output | 32 | Level-sensitive event interrupt lines |
| fault_irq_o | output | 1 | Fault interrupt line |
| release_o | output | 9 | Per-thread release, combinational |

## Verification
The assertions assume that every request, index, select and write input carries a known value on each clock edge once reset is released. They also assume that event indices lie inside the interrupt width, which the 5-bit fields guarantee at the default size. The bench drives every input from time zero, changes them only at the falling edge, and uses full-width index fields, so no unknown or out-of-range value reaches the design. The random phase mixes simultaneous requests from several threads and collisions between acknowledgements and send-events, together with rare faults and a reset in the middle of traffic.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MASK   = 2'd0,
        SEL_ACK    = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_FAULT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               we;
        reg_sel_e           sel;
        logic [DATA_W-1:0]  data;
    } reg_wr_t;

    // thread k's index field inside a packed per-thread index bus
    function automatic int idx_lsb(input int thread, input int idx_w);
        return thread * idx_w;
    endfunction

endpackage

// File: rtl/dma_evt_decode.sv
module dma_evt_decode
    import dma_evt_pkg::*;
#(
    parameter int NUM_EVT = 32,
    parameter int NUM_THR = 9,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_THR-1:0]       sev_valid,
    input  logic [NUM_THR*IDX_W-1:0] sev_idx,
    input  logic [NUM_EVT-1:0]       route_mask,
    output logic [NUM_EVT-1:0]       irq_set,
    output logic [NUM_EVT-1:0]       evt_set
);

    logic [NUM_EVT-1:0] any_req;

    always_comb begin
        any_req = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (sev_valid[t]) begin
                any_req[sev_idx[idx_lsb(t, IDX_W) +: IDX_W]] = 1'b1;
            end
        end
    end

    assign irq_set = any_req & route_mask;
    assign evt_set = any_req & ~route_mask;

endmodule

// File: rtl/dma_evt_irq_bank.sv
module dma_evt_irq_bank #(
    parameter int NUM_EVT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] set_vec,
    input  logic [NUM_EVT-1:0] clr_vec,
    output logic [NUM_EVT-1:0] irq_q
);

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q[n] <= 1'b0;
            end else if (set_vec[n]) begin
                irq_q[n] <= 1'b1;
            end else if (clr_vec[n]) begin
                irq_q[n] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_evt_sync.sv
module dma_evt_sync
    import dma_evt_pkg::*;
#(
    parameter int NUM_EVT = 32,
    parameter int NUM_THR = 9,
    parameter int IDX_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_EVT-1:0]       evt_set,
    input  logic [NUM_THR-1:0]       wait_valid,
    input  logic [NUM_THR*IDX_W-1:0] wait_idx,
    output logic [NUM_THR-1:0]       release_o,
    output logic [NUM_EVT-1:0]       pend_q
);

    logic [NUM_EVT-1:0] served;

    always_comb begin
        served    = '0;
        release_o = '0;
        for (int t = 0; t < NUM_THR; t++) begin
            if (wait_valid[t] && pend_q[wait_idx[idx_lsb(t, IDX_W) +: IDX_W]]) begin
                release_o[t] = 1'b1;
                served[wait_idx[idx_lsb(t, IDX_W) +: IDX_W]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~served) | evt_set;
        end
    end

endmodule

// File: rtl/dma_evt_regs.sv
module dma_evt_regs
    import dma_evt_pkg::*;
#(
    parameter int NUM_EVT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            wr,
    input  reg_sel_e           rd_sel,
    input  logic [NUM_EVT-1:0] irq_lvl,
    input  logic               fault_i,
    output logic [NUM_EVT-1:0] route_mask,
    output logic [NUM_EVT-1:0] ack_vec,
    output logic               fault_clr,
    output logic               fault_q,
    output logic [DATA_W-1:0]  rd_data
);

    assign ack_vec   = (wr.we && wr.sel == SEL_ACK) ? wr.data[NUM_EVT-1:0] : '0;
    assign fault_clr = wr.we && wr.sel == SEL_FAULT && wr.data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            route_mask <= '0;
        end else if (wr.we && wr.sel == SEL_MASK) begin
            route_mask <= wr.data[NUM_EVT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else if (fault_i) begin
            fault_q <= 1'b1;
        end else if (fault_clr) begin
            fault_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_MASK:   rd_data = DATA_W'(route_mask);
            SEL_ACK:    rd_data = '0;
            SEL_STATUS: rd_data = DATA_W'(irq_lvl);
            SEL_FAULT:  rd_data = DATA_W'(fault_q);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_evt_router.sv
module dma_evt_router
    import dma_evt_pkg::*;
#(
    parameter int NUM_EVT = 32,
    parameter int NUM_THR = 9,
    localparam int IDX_W  = $clog2(NUM_EVT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_THR-1:0]       sev_valid_i,
    input  logic [NUM_THR*IDX_W-1:0] sev_idx_i,
    input  logic [NUM_THR-1:0]       wait_valid_i,
    input  logic [NUM_THR*IDX_W-1:0] wait_idx_i,
    input  logic                     fault_i,
    input  logic                     wr_en_i,
    input  logic [SEL_W-1:0]         wr_sel_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [SEL_W-1:0]         rd_sel_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic [NUM_EVT-1:0]       irq_o,
    output logic                     fault_irq_o,
    output logic [NUM_THR-1:0]       release_o
);

    reg_wr_t            wr;
    logic [NUM_EVT-1:0] route_mask;
    logic [NUM_EVT-1:0] ack_vec;
    logic [NUM_EVT-1:0] irq_set;
    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] pend_q;
    logic               fault_clr;

    assign wr.we   = wr_en_i;
    assign wr.sel  = reg_sel_e'(wr_sel_i);
    assign wr.data = wr_data_i;

    dma_evt_regs #(.NUM_EVT(NUM_EVT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_sel     (reg_sel_e'(rd_sel_i)),
        .irq_lvl    (irq_o),
        .fault_i    (fault_i),
        .route_mask (route_mask),
        .ack_vec    (ack_vec),
        .fault_clr  (fault_clr),
        .fault_q    (fault_irq_o),
        .rd_data    (rd_data_o)
    );

    dma_evt_decode #(.NUM_EVT(NUM_EVT), .NUM_THR(NUM_THR), .IDX_W(IDX_W)) u_dec (
        .sev_valid  (sev_valid_i),
        .sev_idx    (sev_idx_i),
        .route_mask (route_mask),
        .irq_set    (irq_set),
        .evt_set    (evt_set)
    );

    dma_evt_irq_bank #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (irq_set),
        .clr_vec (ack_vec),
        .irq_q   (irq_o)
    );

    dma_evt_sync #(.NUM_EVT(NUM_EVT), .NUM_THR(NUM_THR), .IDX_W(IDX_W)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .evt_set    (evt_set),
        .wait_valid (wait_valid_i),
        .wait_idx   (wait_idx_i),
        .release_o  (release_o),
        .pend_q     (pend_q)
    );

endmodule

// File: rtl/dma_evt_router_chk.sv
module dma_evt_router_chk #(
    parameter int NUM_EVT = 32,
    parameter int NUM_THR = 9
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_EVT-1:0] irq_set,
    input logic [NUM_EVT-1:0] evt_set,
    input logic [NUM_EVT-1:0] ack_vec,
    input logic [NUM_EVT-1:0] pend_q,
    input logic [NUM_EVT-1:0] irq_o,
    input logic               fault_i,
    input logic               fault_clr,
    input logic               fault_irq_o,
    input logic [NUM_THR-1:0] wait_valid_i,
    input logic [NUM_THR-1:0] release_o
);

    for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
        AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
            irq_set[n] |=> irq_o[n]);                                  // R3
        AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
            (irq_o[n] && !ack_vec[n]) |=> irq_o[n]);                   // R4
        AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
            (ack_vec[n] && !irq_set[n]) |=> !irq_o[n]);                // R5
        AST_INTERNAL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
            (!irq_o[n] && !irq_set[n]) |=> !irq_o[n]);                 // R2
        AST_EVT_POSTED: assert property (@(posedge clk) disable iff (rst)
            evt_set[n] |=> pend_q[n]);                                 // R2
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        AST_RELEASE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
            release_o[t] |-> wait_valid_i[t]);                         // R8
    end

    AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> fault_irq_o);                                      // R7
    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fault_irq_o && !fault_clr) |=> fault_irq_o);                  // R7

endmodule

bind dma_evt_router dma_evt_router_chk #(.NUM_EVT(NUM_EVT), .NUM_THR(NUM_THR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_set      (irq_set),
    .evt_set      (evt_set),
    .ack_vec      (ack_vec),
    .pend_q       (pend_q),
    .irq_o        (irq_o),
    .fault_i      (fault_i),
    .fault_clr    (fault_clr),
    .fault_irq_o  (fault_irq_o),
    .wait_valid_i (wait_valid_i),
    .release_o    (release_o)
);

// File: tb/dma_evt_router_tb.sv
module dma_evt_router_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int NE = 32;
    localparam int NT = 9;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0]    sev_valid = '0;
    logic [NT*IW-1:0] sev_idx = '0;
    logic [NT-1:0]    wait_valid = '0;
    logic [NT*IW-1:0] wait_idx = '0;
    logic          fault = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_sel = '0;
    logic [31:0]   rd_data;
    logic [NE-1:0] irq;
    logic          fault_irq;
    logic [NT-1:0] rel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    bit [31:0] m_mask, m_irq, m_pend;
    bit        m_fault;

    always #2.5 clk = ~clk;

    dma_evt_router u_dut (
        .clk(clk), .rst(rst),
        .sev_valid_i(sev_valid), .sev_idx_i(sev_idx),
        .wait_valid_i(wait_valid), .wait_idx_i(wait_idx),
        .fault_i(fault), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .irq_o(irq), .fault_irq_o(fault_irq), .release_o(rel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] exp_read(input bit [1:0] s);
        case (s)
            2'd0: return m_mask;
            2'd2: return m_irq;
            2'd3: return {31'b0, m_fault};
            default: return 32'b0;
        endcase
    endfunction

    function automatic bit [NT-1:0] exp_release();
        bit [NT-1:0] r = '0;
        for (int k = 0; k < NT; k++)
            if (wait_valid[k] && m_pend[wait_idx[k*IW +: IW]]) r[k] = 1'b1;
        return r;
    endfunction

    task automatic compare();
        check("R4 irq levels", irq, m_irq);
        check("R7 fault line", {31'b0, fault_irq}, {31'b0, m_fault});
        check("R8 release", {23'b0, rel}, {23'b0, exp_release()});
        check("R11 read data", rd_data, exp_read(rd_sel));
    endtask

    task automatic model_step();
        bit [31:0] iset, eset, served, ack;
        iset = '0; eset = '0; served = '0; ack = '0;
        if (rst) begin
            m_mask = '0; m_irq = '0; m_pend = '0; m_fault = 0;
            return;
        end
        for (int k = 0; k < NT; k++) begin
            if (sev_valid[k]) begin
                if (m_mask[sev_idx[k*IW +: IW]]) iset[sev_idx[k*IW +: IW]] = 1'b1;
                else                              eset[sev_idx[k*IW +: IW]] = 1'b1;
            end
            if (wait_valid[k] && m_pend[wait_idx[k*IW +: IW]]) served[wait_idx[k*IW +: IW]] = 1'b1;
        end
        if (wr_en && wr_sel == 2'd1) ack = wr_data;
        m_irq  = (m_irq & ~ack) | iset;
        m_pend = (m_pend & ~served) | eset;
        if (fault) m_fault = 1;
        else if (wr_en && wr_sel == 2'd3 && wr_data[0]) m_fault = 0;
        if (wr_en && wr_sel == 2'd0) m_mask = wr_data;
    endtask

    // one clock: compare now, advance model, move to next falling edge, drop pulses
    task automatic cyc();
        #1;
        compare();
        model_step();
        @(negedge clk);
        sev_valid = '0; wr_en = 0; fault = 0;
    endtask

    task automatic sev(input int thr, input int idx);
        sev_valid[thr] = 1'b1;
        sev_idx[thr*IW +: IW] = IW'(idx);
    endtask

    task automatic waitq(input int thr, input int idx);
        wait_valid[thr] = 1'b1;
        wait_idx[thr*IW +: IW] = IW'(idx);
    endtask

    task automatic wr(input bit [1:0] s, input bit [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1;
        cyc(); cyc();
        rst = 0;
        // R1: reset state
        #1;
        check("R1 irq after reset", irq, 32'h0);
        check("R1 fault after reset", {31'b0, fault_irq}, 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #0.1;
            check("R1 read after reset", rd_data, 32'h0);
        end
        rd_sel = 0;
        cyc();

        // R2: unmasked event goes internal
        sev(3, 5);
        cyc();
        #1 check("R2 no irq on internal event", irq, 32'h0);
        // R8: waiting threads on 5 released, thread on 6 not
        waitq(0, 5); waitq(8, 5); waitq(1, 6);
        #0.1 check("R8 release on posted event", {23'b0, rel}, 32'h101);
        cyc();
        #1 check("R9 withdrawn after release", {23'b0, rel}, 32'h0);
        wait_valid = '0;
        cyc();

        // R9: event held while nobody waits
        sev(2, 7);
        cyc(); cyc(); cyc(); cyc();
        waitq(2, 7);
        #1 check("R9 event held until waited", {23'b0, rel}, 32'h4);
        cyc();
        wait_valid = '0;
        cyc();

        // R10: mask write and send-event together use old mask
        wr(2'd0, 32'h0000_0011); sev(1, 0);
        cyc();
        rd_sel = 2'd0;
        #1 check("R10 old mask routes event", irq, 32'h0);
        check("R10 mask readback", rd_data, 32'h0000_0011);
        cyc();

        // R3 + R12: two threads, two routed events
        sev(6, 4); sev(8, 0);
        cyc();
        #1 check("R3 R12 routed irq raised", irq, 32'h0000_0011);
        cyc(); cyc(); cyc();
        rd_sel = 2'd2;
        #1 check("R4 irq persists", irq, 32'h0000_0011);
        check("R11 status read", rd_data, 32'h0000_0011);

        // R5: acknowledge bit 0 only
        wr(2'd1, 32'h0000_0001);
        cyc();
        rd_sel = 2'd1;
        #1 check("R5 ack clears one line", irq, 32'h0000_0010);
        check("R5 ack word reads zero", rd_data, 32'h0);

        // R6: set beats ack
        sev(4, 4); wr(2'd1, 32'h0000_0010);
        cyc();
        #1 check("R6 set wins over ack", irq, 32'h0000_0010);
        wr(2'd1, 32'h0000_0010);
        cyc();
        #1 check("R5 ack after collision", irq, 32'h0);

        // R7: fault flag
        rd_sel = 2'd3;
        fault = 1;
        cyc();
        #1 check("R7 fault raised", {31'b0, fault_irq}, 32'h1);
        check("R7 fault readback", rd_data, 32'h1);
        wr(2'd3, 32'h0);
        cyc();
        #1 check("R7 zero write keeps fault", {31'b0, fault_irq}, 32'h1);
        fault = 1; wr(2'd3, 32'h1);
        cyc();
        #1 check("R7 new fault beats clear", {31'b0, fault_irq}, 32'h1);
        wr(2'd3, 32'h1);
        cyc();
        #1 check("R7 fault cleared", {31'b0, fault_irq}, 32'h0);

        // random traffic compared every cycle
        for (int i = 0; i < 4000; i++) begin
            for (int k = 0; k < NT; k++) begin
                if ($urandom_range(0, 5) == 0) sev(k, $urandom_range(0, 31));
                wait_valid[k] = ($urandom_range(0, 3) == 0);
                wait_idx[k*IW +: IW] = IW'($urandom_range(0, 31));
            end
            if ($urandom_range(0, 4) == 0)
                wr(2'($urandom_range(0, 3)), $urandom());
            fault = ($urandom_range(0, 60) == 0);
            rd_sel = 2'($urandom_range(0, 3));
            if (i == 2500) rst = 1;
            if (i == 2502) rst = 0;
            cyc();
        end
        wait_valid = '0;
        rst = 1;
        cyc();
        rst = 0;
        #1 check("R1 outputs after late reset", {irq[30:0], fault_irq}, 32'h0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule